// File: doc/BRIEF.md
# Machine-Cycle Timer and Falling-Edge Event Counter

This block keeps a 16-bit count, held as a low byte and a high byte, that advances in one of two ways. In timer mode it advances once per machine cycle. A machine cycle is twelve clocks long. In event mode it advances once for each high-to-low change seen on an external input. That input is sampled once per machine cycle, at a fixed phase. An edge is accepted only when one sample is high and the following sample is low. For this reason the count can advance at most once every twenty-four clocks.

Software reaches the block through a simple write port with a byte select. It can load either count byte, or load the control byte. The control byte holds the run enable, the mode select and the rollover flag. The count, the rollover flag, the mode and the run bit are always visible on the outputs.

Inside the block, a free-running phase counter steps from 0 to 11. The input is sampled at phase 9. Any pending edge, or the timer tick, is applied at phase 2 of the following machine cycle. The new value is therefore visible from the clock after that phase-2 edge.

Top module: `evt_timer16`

## Requirements
- R1: After reset, count_o is 0000h, ovf_o is 0, mode_o is 0 (timer mode) and run_o is 0.
- R2: While run_o is 0 and no count byte is written, count_o does not change.
- R3: In timer mode with run_o at 1, count_o advances by exactly one per twelve clocks, and never by more than one in a single clock.
- R4: In event mode, ext_in is sampled at phase 9. A high sample followed by a low sample at the next phase 9 makes the count advance by one at the following phase 2.
- R5: In event mode, two successive advances are never closer than 24 clocks apart.
- R6: In event mode, an input held steady at either level never advances the count.
- R7: When the count rolls over from FFFFh to 0000h, ovf_o becomes 1. A rollover in the same clock as a control write wins over that write.
- R8: A control write (wr_sel = 2) loads ovf_o from wr_data bit 2, so writing 0 there clears the flag.
- R9: A write with wr_sel = 0 loads the low byte, and one with wr_sel = 1 loads the high byte. The other byte keeps its value. wr_sel = 3 has no effect.
- R10: A write to either count byte in the same clock as an advance cancels the advance. The written byte takes wr_data and the rollover flag is not set.
- R11: A control write loads run_o from wr_data bit 0 and mode_o from wr_data bit 1 (1 = event mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External event input, already synchronous to clk |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 low byte, 1 high byte, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| count_o | output | 16 | Current count, high byte above low byte |
| ovf_o | output | 1 | Rollover flag |
| mode_o | output | 1 | 0 timer mode, 1 event mode |
| run_o | output | 1 | Run enable |

## Verification
In timer mode the count is measured over whole multiples of twelve clocks, which catches a wrong machine-cycle length. Event mode is tried with three kinds of input. A steady high or low level must never advance the count. A square wave with a 24-clock period must advance it about once per 24 clocks. Random edges are also applied, and these separate a correct falling-edge detector from one that reacts to rising edges or samples at the wrong phase. Further cases load FFFFh so the rollover can be watched, and place byte writes exactly on the phase-2 advance clock to test which one takes priority.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int PHASES    = 12;
    localparam int PH_W      = $clog2(PHASES);
    localparam int SAMPLE_PH = 9;
    localparam int UPDATE_PH = 2;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_MODE = 1;
    localparam int CTRL_OVF  = 2;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic run;
        logic mode;
        logic ovf;
    } ctrl_t;
endpackage

// File: rtl/et_phase_gen.sv
module et_phase_gen
    import evt_timer16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic            is_sample_o,
    output logic            is_update_o
);
    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == PH_W'(PHASES - 1)) ? '0 : phase_q + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign is_sample_o = (phase_q == PH_W'(SAMPLE_PH));
    assign is_update_o = (phase_q == PH_W'(UPDATE_PH));
endmodule

// File: rtl/et_fall_detect.sv
module et_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic consume_en,
    input  logic pin_i,
    output logic pend_o
);
    typedef struct packed {
        logic last;
        logic pend;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_en) begin
            st_d.pend = st_q.last & ~pin_i;
            st_d.last = pin_i;
        end else if (consume_en) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/et_count_core.sv
module et_count_core
    import evt_timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              wrap_o
);
    logic [BYTE_W-1:0] lo_d, lo_q, hi_d, hi_q;
    logic              wr_any;

    always_comb begin
        wr_any = wr_lo_i | wr_hi_i;
        lo_d   = lo_q;
        hi_d   = hi_q;
        wrap_o = 1'b0;
        if (wr_any) begin
            if (wr_lo_i) lo_d = data_i;
            if (wr_hi_i) hi_d = data_i;
        end else if (inc_i) begin
            {hi_d, lo_d} = {hi_q, lo_q} + CNT_W'(1);
            wrap_o       = &{hi_q, lo_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign count_o = {hi_q, lo_q};
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
    import evt_timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o,
    output logic              mode_o,
    output logic              run_o
);
    ctrl_t ctrl_d, ctrl_q;
    logic  is_sample, is_update, pend, inc, wrap;
    logic  wr_lo, wr_hi, wr_ctrl;

    et_phase_gen u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_sample_o (is_sample),
        .is_update_o (is_update)
    );

    et_fall_detect u_fall (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (is_sample),
        .consume_en (is_update),
        .pin_i      (ext_in),
        .pend_o     (pend)
    );

    et_count_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (inc),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .data_i  (wr_data),
        .count_o (count_o),
        .wrap_o  (wrap)
    );

    always_comb begin
        wr_lo   = wr_en && (wr_sel == SEL_LO);
        wr_hi   = wr_en && (wr_sel == SEL_HI);
        wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
        inc     = ctrl_q.run && is_update && (ctrl_q.mode ? pend : 1'b1);

        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.run  = wr_data[CTRL_RUN];
            ctrl_d.mode = wr_data[CTRL_MODE];
            ctrl_d.ovf  = wr_data[CTRL_OVF];
        end
        if (wrap) ctrl_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ovf_o  = ctrl_q.ovf;
    assign mode_o = ctrl_q.mode;
    assign run_o  = ctrl_q.run;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [7:0]  wr_data,
    input logic [15:0] count_o,
    input logic        ovf_o,
    input logic        mode_o,
    input logic        run_o
);
    logic [15:0] prev_cnt_q;
    logic        prev_wr_q, valid_q, armed_q;
    logic [4:0]  gap_q;
    logic        adv;

    assign adv = valid_q && !prev_wr_q && (count_o != prev_cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_cnt_q <= '0;
            prev_wr_q  <= 1'b0;
            valid_q    <= 1'b0;
            armed_q    <= 1'b0;
            gap_q      <= '0;
        end else begin
            prev_cnt_q <= count_o;
            prev_wr_q  <= wr_en;
            valid_q    <= 1'b1;
            if (wr_en) begin
                armed_q <= 1'b0;
                gap_q   <= '0;
            end else if (adv) begin
                armed_q <= 1'b1;
                gap_q   <= '0;
            end else if (gap_q != 5'd31) begin
                gap_q   <= gap_q + 5'd1;
            end
        end
    end

    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !wr_en) |=> $stable(count_o));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (count_o == $past(count_o) || count_o == $past(count_o) + 16'd1));

    assert_event_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode_o && armed_q) |-> (gap_q >= 5'd23));

    assert_ovf_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && count_o == 16'hFFFF) |=> (count_o == 16'hFFFF || ovf_o));

    assert_lo_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (count_o[7:0] == $past(wr_data)
                                      && count_o[15:8] == $past(count_o[15:8])));

    assert_ctrl_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> (run_o == $past(wr_data[0]) && mode_o == $past(wr_data[1])));
endmodule

bind evt_timer16 evt_timer16_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .count_o (count_o),
    .ovf_o   (ovf_o),
    .mode_o  (mode_o),
    .run_o   (run_o)
);

// File: tb/evt_timer16_tb.sv
`timescale 1ns/1ps
module evt_timer16_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [7:0]  wr_data = '0;
    logic [15:0] count_o;
    logic        ovf_o, mode_o, run_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state, advanced from the requirements
    int          m_phase = 0;
    logic        m_last = 1'b0, m_pend = 1'b0;
    logic [15:0] m_cnt = '0;
    logic        m_run = 1'b0, m_mode = 1'b0, m_ovf = 1'b0;

    always #2.5 clk = ~clk;

    evt_timer16 u_dut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .count_o(count_o),
        .ovf_o(ovf_o), .mode_o(mode_o), .run_o(run_o)
    );

    function automatic logic model_inc(int ph, logic run, logic mode, logic pend);
        return run && (ph == 2) && (mode ? pend : 1'b1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_last = 0; m_pend = 0;
            m_cnt = '0; m_run = 0; m_mode = 0; m_ovf = 0;
        end else begin
            logic inc, wrapped;
            inc = model_inc(m_phase, m_run, m_mode, m_pend);
            wrapped = 1'b0;
            if (wr_en && wr_sel == 2'd0)      m_cnt[7:0]  = wr_data;
            else if (wr_en && wr_sel == 2'd1) m_cnt[15:8] = wr_data;
            else if (inc) begin
                wrapped = (m_cnt == 16'hFFFF);
                m_cnt = m_cnt + 16'd1;
            end
            if (wr_en && wr_sel == 2'd2) begin
                m_run = wr_data[0]; m_mode = wr_data[1]; m_ovf = wr_data[2];
            end
            if (wrapped) m_ovf = 1'b1;
            if (m_phase == 9) begin
                m_pend = m_last & ~ext_in;
                m_last = ext_in;
            end else if (m_phase == 2) m_pend = 1'b0;
            m_phase = (m_phase == 11) ? 0 : m_phase + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmp_model(string req);
        check({req, " count"}, {16'd0, count_o}, {16'd0, m_cnt});
        check("R7/R8 ovf", {31'd0, ovf_o}, {31'd0, m_ovf});
    endtask

    // advance n clocks; inputs change and outputs are sampled at negedge
    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick(1);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic wait_phase(int ph);
        while (m_phase != ph) tick(1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] base;
        void'($urandom(32'd1234));
        tick(3);
        // R1 reset values
        check("R1 count", {16'd0, count_o}, 32'd0);
        check("R1 ovf",  {31'd0, ovf_o},  32'd0);
        check("R1 mode", {31'd0, mode_o}, 32'd0);
        check("R1 run",  {31'd0, run_o},  32'd0);
        rst_n = 1'b1;
        tick(50);
        check("R2 stopped", {16'd0, count_o}, 32'd0);

        // R11 control readback, R3 timer rate
        wr(2'd2, 8'h01);
        check("R11 run", {31'd0, run_o}, 32'd1);
        check("R11 mode", {31'd0, mode_o}, 32'd0);
        base = count_o;
        tick(120);
        check("R3 timer 10 per 120", {16'd0, count_o - base}, 32'd10);
        cmp_model("R3");

        // R6 steady levels in event mode
        wr(2'd2, 8'h03);
        check("R11 event mode", {31'd0, mode_o}, 32'd1);
        ext_in = 1'b1; tick(30); base = count_o;
        tick(120);
        check("R6 steady high", {16'd0, count_o - base}, 32'd0);
        ext_in = 1'b0; tick(30); base = count_o;
        tick(120);
        check("R6 steady low", {16'd0, count_o - base}, 32'd0);

        // R4/R5 square wave, 24-clock period
        base = count_o;
        for (int k = 0; k < 20; k++) begin
            ext_in = ~ext_in; tick(12);
        end
        checks++;
        if ((count_o - base) > 16'd10 || (count_o - base) < 16'd9) begin
            failures++;
            $display("FAIL R5 actual=%0d expected=9..10", count_o - base);
        end
        cmp_model("R4");

        // R4 single directed falling edge
        ext_in = 1'b1;
        wait_phase(10); tick(12);
        ext_in = 1'b0; base = count_o;
        wait_phase(3);
        wait_phase(10); wait_phase(3);
        check("R4 one edge", {16'd0, count_o - base}, 32'd1);

        // R7 rollover in timer mode, R8 clear
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        check("R9 load FFFF", {16'd0, count_o}, 32'h0000FFFF);
        wr(2'd2, 8'h01);
        wait_phase(3);
        check("R7 wrap count", {16'd0, count_o}, 32'd0);
        check("R7 ovf set", {31'd0, ovf_o}, 32'd1);
        wr(2'd2, 8'h01);
        check("R8 ovf cleared", {31'd0, ovf_o}, 32'd0);

        // R9 byte independence and ignored select
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'hA5);
        check("R9 bytes", {16'd0, count_o}, 32'h0000A53C);
        wr(2'd3, 8'h77);
        check("R9 sel3 no effect", {16'd0, count_o}, 32'h0000A53C);

        // R10 write on advance clock, including FFFF wrap cancelled
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        wr(2'd2, 8'h01);
        wait_phase(2);
        wr(2'd0, 8'h55);
        check("R10 write wins", {16'd0, count_o}, 32'h0000FF55);
        check("R10 no ovf", {31'd0, ovf_o}, 32'd0);
        wait_phase(2);
        wr(2'd1, 8'h12);
        check("R10 hi write wins", {16'd0, count_o}, 32'h00001255);

        // random mix checked each clock against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) begin
                wr_en = 1'b1;
                wr_sel = 2'($urandom_range(0, 3));
                wr_data = 8'($urandom);
                if (wr_sel == 2'd2) wr_data[0] = 1'b1;
            end else begin
                wr_en = 1'b0; wr_sel = 2'd3;
            end
            if ($urandom_range(0, 9) == 0) ext_in = ~ext_in;
            tick(1);
            cmp_model("R3/R4/R9");
        end
        wr_en = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule